// File: doc/BRIEF.md
# SPI Master with Parked Data-Out Level

This block is a single-lane SPI master that sends one 8-bit frame per start request in mode 0. SCLK rests low. Data leaves on MOSI most significant bit first, and both ends capture on the rising SCLK edge. An active-low chip select frames each frame. The SCLK half-period is set by a divider register.

The block also gives a defined level to MOSI whenever no bit is being shifted out. A configuration word can park the line high or low. That level holds while chip select is released, and also inside chip select before the first bit window opens and after the last one closes. With neither option chosen, MOSI keeps the last bit sent, which is the conventional behaviour. If both options are requested together, the block flags a configuration error and refuses to start.

Host logic writes the configuration word and the divider through `cfg_we`. It then pulses `start` with the byte to send, waits for `done`, and reads `rx_byte`.

Top module: `spi_idle_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `cfg_err` is 0.
- R2: A started frame drops `cs_n`. For the first H = `cfg_div`+1 clocks no bit is presented. Each of the 8 bits, MSB first, is then driven for 2H clocks. SCLK is low in the first H clocks of a bit's window and high in the second H. MOSI never changes while SCLK is high.
- R3: MISO is captured on each rising SCLK edge, MSB first. The captured byte appears on `rx_byte` in the same cycle as `done` and stays there.
- R4: With bit 18 of the configuration word set (and bit 17 clear), MOSI is 1 whenever no bit window is open. This covers `cs_n` high, the first H clocks after `cs_n` falls, and the H clocks after the last falling SCLK edge.
- R5: With bit 17 set (and bit 18 clear), MOSI is 0 at all the same times as in R4.
- R6: With bits 17 and 18 both clear, MOSI keeps its previous value outside the bit windows. That is the last bit of the previous frame, or 0 after reset.
- R7: With bits 17 and 18 both set, `cfg_err` is 1 one cycle after the write, and `start` is ignored: `cs_n` stays 1 and `busy` stays 0.
- R8: While `busy` is 1, `start` and configuration writes have no effect. The running frame completes unchanged, `cfg_err` does not change, and no new frame follows.
- R9: `cs_n` rises 18H clocks after the start is sampled. `done` is high for exactly that one cycle, and `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write `cfg_mode` and `cfg_div` (taken only when idle) |
| cfg_mode | input | 32 | Configuration word; bit 17 parks MOSI low, bit 18 parks it high |
| cfg_div | input | 8 | SCLK half-period minus one, in system clocks |
| tx_byte | input | 8 | Byte to send, sampled with `start` |
| start | input | 1 | Start strobe |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when chip select releases |
| rx_byte | output | 8 | Last received byte |
| cfg_err | output | 1 | Both park levels requested |
| sclk | output | 1 | Serial clock, rests low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
The bench counts cycle n from the clock edge that samples `start`. All outputs are registered, so each expected value is a closed-form function of n and H: bit k opens at n = H + 2kH, SCLK rises at n = 2H + 2kH, the last window closes at 17H, and chip select and `done` change at 18H. It drives inputs and compares every output on falling clock edges, at every cycle of the frame, so a result that comes a cycle early or late is seen. MISO bits are placed when each window opens, a full half-period before the rising edge that samples them. The parked level is checked one cycle after the configuration write.

// File: rtl/spi_idle_ctrl.sv
module spi_idle_ctrl #(
  parameter int MODE_W = 32,
  parameter int DIV_W  = 8,
  parameter int FW     = 8,
  parameter int LO_BIT = 17,
  parameter int HI_BIT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [FW-1:0]     tx_byte,
  input  logic              start,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [FW-1:0]     rx_byte,
  output logic              cfg_err,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);
  localparam int BW = $clog2(FW);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_TRAIL} st_t;

  st_t              state;
  logic             idle_lo, idle_hi;
  logic [DIV_W-1:0] div_r, cnt;
  logic [BW-1:0]    bitn;
  logic [FW-1:0]    tx_sh, rx_sh;

  wire park   = idle_lo ^ idle_hi;
  wire tick   = (cnt == div_r);
  wire in_idl = (state == S_IDLE);
  wire cfg_ok = cfg_we && in_idl;
  wire go     = start && in_idl && !cfg_we && !cfg_err;

  assign busy    = !in_idl;
  assign cfg_err = idle_lo & idle_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idle_lo <= 1'b0;
      idle_hi <= 1'b0;
      div_r   <= '0;
      cnt     <= '0;
      bitn    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!in_idl) cnt <= tick ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          if (cfg_ok) begin
            idle_lo <= cfg_mode[LO_BIT];
            idle_hi <= cfg_mode[HI_BIT];
            div_r   <= cfg_div;
            if (cfg_mode[LO_BIT] ^ cfg_mode[HI_BIT]) mosi <= cfg_mode[HI_BIT];
          end else if (go) begin
            state <= S_SETUP;
            cs_n  <= 1'b0;
            cnt   <= '0;
            tx_sh <= tx_byte;
          end
        end
        S_SETUP: if (tick) begin
          state <= S_LOW;
          bitn  <= '0;
          mosi  <= tx_sh[FW-1];
        end
        S_LOW: if (tick) begin
          state <= S_HIGH;
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[FW-2:0], miso};
        end
        S_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bitn == BW'(FW-1)) begin
            state <= S_TRAIL;
            if (park) mosi <= idle_hi;
          end else begin
            state <= S_LOW;
            bitn  <= bitn + 1'b1;
            tx_sh <= tx_sh << 1;
            mosi  <= tx_sh[FW-2];
          end
        end
        S_TRAIL: if (tick) begin
          state   <= S_IDLE;
          cs_n    <= 1'b1;
          done    <= 1'b1;
          rx_byte <= rx_sh;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  p_park_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && idle_hi && !idle_lo) |-> mosi);
  p_park_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && idle_lo && !idle_hi) |-> !mosi);
  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !busy && !cfg_we) |=> !busy);
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cfg_err));
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (done && !busy));
endmodule

// File: tb/test_spi_idle_ctrl.sv
module test_spi_idle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_mode = '0;
  logic [7:0]  cfg_div = '0;
  logic [7:0]  tx_byte = '0;
  logic        start = 1'b0;
  logic        miso = 1'b0;
  logic        busy, done, cfg_err, sclk, cs_n, mosi;
  logic [7:0]  rx_byte;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  spi_idle_ctrl i_spi_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_div(cfg_div), .tx_byte(tx_byte), .start(start), .miso(miso),
    .busy(busy), .done(done), .rx_byte(rx_byte), .cfg_err(cfg_err),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk(cs_n, 1, "R1 cs_n");
    chk(sclk, 0, "R1 sclk");
    chk(mosi, 0, "R1 mosi");
    chk(busy, 0, "R1 busy");
    chk(cfg_err, 0, "R1 cfg_err");
  endtask

  task automatic run_xfer(input logic [31:0] mode, input logic [7:0] div,
                          input logic [7:0] tx, input logic [7:0] slv,
                          input bit inject, input string req);
    int   h = int'(div) + 1;
    logic park = mode[17] ^ mode[18];
    logic pre;
    logic em;
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = mode; cfg_div = div;
    @(negedge clk);
    cfg_we = 1'b0;
    pre = park ? mode[18] : mosi;
    chk(mosi, pre, {req, " parked before start"});
    tx_byte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tx_byte = ~tx;
    for (int n = 0; n <= 18*h + 1; n++) begin
      if (n >= h && n < 17*h && (n - h) % (2*h) == 0) miso = slv[7 - (n - h)/(2*h)];
      if (n < h) em = pre;
      else if (n < 17*h) em = tx[7 - (n - h)/(2*h)];
      else em = park ? mode[18] : tx[0];
      chk(mosi, em, (n < h || n >= 17*h) ? {req, " mosi outside bit window"} : "R2 mosi bit");
      chk(sclk, (n >= 2*h && n < 17*h && ((n - 2*h)/h) % 2 == 0), "R2 sclk");
      chk(cs_n, (n >= 18*h), "R9 cs_n");
      chk(done, (n == 18*h), "R9 done");
      chk(busy, (n < 18*h), "R9 busy");
      if (n == 18*h) chk(rx_byte, slv, "R3 rx_byte at done");
      if (n == 18*h + 1) chk(rx_byte, slv, "R3 rx_byte held");
      if (inject && n == 2) begin
        start = 1'b1; cfg_we = 1'b1; cfg_mode = 32'h0006_0000; cfg_div = 8'd0; tx_byte = 8'h00;
      end
      if (inject && n == 3) begin
        start = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    if (inject) begin
      for (int k = 0; k < 4; k++) begin
        chk(cs_n, 1, "R8 no second frame");
        chk(cfg_err, 0, "R8 config write ignored");
        @(negedge clk);
      end
    end
  endtask

  task automatic t_conflict();
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 32'h0006_0000; cfg_div = 8'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err, 1, "R7 cfg_err set");
    start = 1'b1; tx_byte = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(cs_n, 1, "R7 cs_n stays high");
      chk(busy, 0, "R7 busy stays low");
      chk(sclk, 0, "R7 sclk stays low");
      @(negedge clk);
    end
    cfg_we = 1'b1; cfg_mode = 32'h0004_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err, 0, "R7 cfg_err clears");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_xfer(32'h0004_0000, 8'd0, 8'hA5, 8'h3C, 1'b0, "R4");
    run_xfer(32'h0004_0000, 8'd2, 8'h56, 8'hBA, 1'b0, "R4");
    run_xfer(32'h0002_0000, 8'd1, 8'hFF, 8'h81, 1'b0, "R5");
    run_xfer(32'h0000_0000, 8'd0, 8'h01, 8'h55, 1'b0, "R6");
    run_xfer(32'h0000_0000, 8'd3, 8'h80, 8'hAA, 1'b0, "R6");
    t_conflict();
    run_xfer(32'h0004_0000, 8'd1, 8'hC3, 8'h5A, 1'b1, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule